// File: doc/BRIEF.md
# Rotating Register Base Renamer

This block turns virtual register numbers into physical register numbers for three register classes: general, floating-point and predicate. Each class has its own rotating base, which is held in a register. A lookup is purely combinational. Each class has one lookup port. A virtual number that falls inside the class's rotating region is offset by that class's base and wrapped so that it stays inside the region. A virtual number outside the region comes out unchanged.

A single rotate strobe, raised by a loop branch, steps all three bases down by one in the same clock. A clear strobe sets all three bases back to zero. The floating-point region and the predicate region have fixed bounds. The general region starts at register 32 and its length is programmable in groups of eight registers. Software-pipelined loops use this scheme so that a value written by one iteration is read under a different name by a later iteration, without any copy instructions.

Top module: `rot_base_renamer`

## Requirements
- R1: After reset all three bases are zero, so every lookup port returns its virtual number unchanged.
- R2: A rotate strobe without clear lowers all three bases by one on the same clock edge. A base of zero wraps to its region size minus one (95 for floating-point, 47 for predicate, general size minus one for general).
- R3: The floating-point region is registers 32 to 127 (96 entries). Inside it the physical number is 32 + ((v − 32 + base) mod 96). After one rotate from reset, virtual 32 gives 127 and virtual 33 gives 32.
- R4: The predicate region is registers 16 to 63 (48 entries). Inside it the physical number is 16 + ((v − 16 + base) mod 48). After one rotate from reset, virtual 16 gives 63.
- R5: The general region starts at 32 and is 8 × `gr_grp_i` registers long. Group counts above 12 are treated as 12. Inside the region the physical number is 32 + ((v − 32 + base) mod size).
- R6: Virtual numbers outside a class's region come out unchanged. This covers floating-point 0–31, predicate 0–15, and general numbers below 32 or at or above 32 + size.
- R7: A clear strobe sets all three bases to zero on the next edge. Clear takes priority over a rotate in the same cycle.
- R8: With `gr_grp_i` equal to 0, general rotation is off. The general port passes every number through, and the general base stays zero across rotates.
- R9: If the general base is not below the current general size (the region was shrunk), lookups use a base of zero. The next rotate then sets the base to size minus one.
- R10: Lookups use the base held at the start of the cycle. A rotate or clear strobe changes the mapping starting with the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rotate_i | input | 1 | Loop-branch strobe; steps all bases down by one |
| clear_i | input | 1 | Sets all bases to zero |
| gr_grp_i | input | 4 | General rotating size, in groups of eight registers |
| gr_vidx_i | input | 7 | General virtual register number |
| fr_vidx_i | input | 7 | Floating-point virtual register number |
| pr_vidx_i | input | 6 | Predicate virtual register number |
| gr_pidx_o | output | 7 | General physical register number |
| fr_pidx_o | output | 7 | Floating-point physical register number |
| pr_pidx_o | output | 6 | Predicate physical register number |

## Verification
The bound checker watches several rules on every cycle. It checks the one-step decrement and its wrap for the floating-point and predicate bases, and that clear zeroes all bases and wins over rotate. It checks that bases hold when no strobe is present. It also checks that static floating-point and predicate numbers pass through, that floating-point region numbers stay in the region, and that the general port passes through when its size is zero. Some behaviour needs a sequence of stimulus and is shown only by the bench's scenarios. This includes the exact modular mapping after many rotations, wrap-around after a full turn of each region, and clamping of the group count. It also includes the treatment of a stale general base after the region shrinks, and the one-cycle delay between a strobe and the changed mapping.

// File: rtl/rrn_pkg.sv
package rrn_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_ROTATE = 2'd1,
        ACT_CLEAR  = 2'd2
    } rot_act_e;

    // Clear outranks rotate.
    function automatic rot_act_e decode_act(input logic rotate, input logic clear);
        if (clear)       return ACT_CLEAR;
        else if (rotate) return ACT_ROTATE;
        else             return ACT_HOLD;
    endfunction

endpackage

// File: rtl/rrn_base_step.sv
module rrn_base_step
    import rrn_pkg::*;
#(
    parameter int W = 7
) (
    input  logic [W-1:0] base_q,
    input  logic [W-1:0] size,
    input  rot_act_e     act,
    output logic [W-1:0] base_d
);

    always_comb begin
        base_d = base_q;
        unique case (act)
            ACT_CLEAR: base_d = '0;
            ACT_ROTATE: begin
                if (size == '0)
                    base_d = '0;
                else if (base_q == '0 || base_q >= size)
                    base_d = size - W'(1);
                else
                    base_d = base_q - W'(1);
            end
            default: base_d = base_q;
        endcase
    end

endmodule

// File: rtl/rrn_index_map.sv
module rrn_index_map #(
    parameter int W  = 7,
    parameter int LO = 32
) (
    input  logic [W-1:0] vidx,
    input  logic [W-1:0] size,
    input  logic [W-1:0] base,
    output logic [W-1:0] pidx
);

    localparam logic [W:0] LO_X = (W+1)'(LO);

    logic [W:0] rel;
    logic [W:0] sum;
    logic [W:0] size_x;
    logic [W:0] eff_base;
    logic       in_region;

    always_comb begin
        size_x    = {1'b0, size};
        rel       = {1'b0, vidx} - LO_X;
        in_region = ({1'b0, vidx} >= LO_X) && (rel < size_x);
        eff_base  = (base >= size) ? '0 : {1'b0, base};
        sum       = rel + eff_base;
        if (sum >= size_x)
            sum = sum - size_x;
        pidx = in_region ? W'(sum + LO_X) : vidx;
    end

endmodule

// File: rtl/rot_base_renamer.sv
module rot_base_renamer
    import rrn_pkg::*;
#(
    parameter int GR_REGS = 128,
    parameter int GR_LO   = 32,
    parameter int FR_REGS = 128,
    parameter int FR_LO   = 32,
    parameter int PR_REGS = 64,
    parameter int PR_LO   = 16,
    parameter int GRP     = 8,
    localparam int GR_W      = $clog2(GR_REGS),
    localparam int FR_W      = $clog2(FR_REGS),
    localparam int PR_W      = $clog2(PR_REGS),
    localparam int GR_MAXGRP = (GR_REGS - GR_LO) / GRP,
    localparam int GRP_W     = $clog2(GR_MAXGRP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rotate_i,
    input  logic             clear_i,
    input  logic [GRP_W-1:0] gr_grp_i,
    input  logic [GR_W-1:0]  gr_vidx_i,
    input  logic [FR_W-1:0]  fr_vidx_i,
    input  logic [PR_W-1:0]  pr_vidx_i,
    output logic [GR_W-1:0]  gr_pidx_o,
    output logic [FR_W-1:0]  fr_pidx_o,
    output logic [PR_W-1:0]  pr_pidx_o
);

    localparam logic [FR_W-1:0]  FR_SIZE  = FR_W'(FR_REGS - FR_LO);
    localparam logic [PR_W-1:0]  PR_SIZE  = PR_W'(PR_REGS - PR_LO);
    localparam logic [GRP_W-1:0] GRP_MAXV = GRP_W'(GR_MAXGRP);

    typedef struct packed {
        logic [GR_W-1:0] gr;
        logic [FR_W-1:0] fr;
        logic [PR_W-1:0] pr;
    } base_t;

    base_t           st_d, st_q;
    rot_act_e        act;
    logic [GRP_W-1:0] grp_clamped;
    logic [GR_W-1:0] gr_size;
    logic [GR_W-1:0] gr_next;
    logic [FR_W-1:0] fr_next;
    logic [PR_W-1:0] pr_next;
    logic [GR_W-1:0] gr_base;
    logic [FR_W-1:0] fr_base;
    logic [PR_W-1:0] pr_base;

    always_comb begin
        act         = decode_act(rotate_i, clear_i);
        grp_clamped = (gr_grp_i > GRP_MAXV) ? GRP_MAXV : gr_grp_i;
        gr_size     = GR_W'(grp_clamped) * GR_W'(GRP);
        st_d.gr     = gr_next;
        st_d.fr     = fr_next;
        st_d.pr     = pr_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gr_base = st_q.gr;
    assign fr_base = st_q.fr;
    assign pr_base = st_q.pr;

    rrn_base_step #(.W(GR_W)) u_gr_step (
        .base_q (gr_base), .size (gr_size), .act (act), .base_d (gr_next)
    );
    rrn_base_step #(.W(FR_W)) u_fr_step (
        .base_q (fr_base), .size (FR_SIZE), .act (act), .base_d (fr_next)
    );
    rrn_base_step #(.W(PR_W)) u_pr_step (
        .base_q (pr_base), .size (PR_SIZE), .act (act), .base_d (pr_next)
    );

    rrn_index_map #(.W(GR_W), .LO(GR_LO)) u_gr_map (
        .vidx (gr_vidx_i), .size (gr_size), .base (gr_base), .pidx (gr_pidx_o)
    );
    rrn_index_map #(.W(FR_W), .LO(FR_LO)) u_fr_map (
        .vidx (fr_vidx_i), .size (FR_SIZE), .base (fr_base), .pidx (fr_pidx_o)
    );
    rrn_index_map #(.W(PR_W), .LO(PR_LO)) u_pr_map (
        .vidx (pr_vidx_i), .size (PR_SIZE), .base (pr_base), .pidx (pr_pidx_o)
    );

endmodule

// File: rtl/rot_base_renamer_chk.sv
module rot_base_renamer_chk #(
    parameter int GR_W  = 7,
    parameter int FR_W  = 7,
    parameter int PR_W  = 6,
    parameter int GRP_W = 4,
    parameter int FR_LO = 32,
    parameter int PR_LO = 16,
    parameter int FR_SZ = 96,
    parameter int PR_SZ = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rotate_i,
    input logic             clear_i,
    input logic [GRP_W-1:0] gr_grp_i,
    input logic [GR_W-1:0]  gr_vidx_i,
    input logic [FR_W-1:0]  fr_vidx_i,
    input logic [PR_W-1:0]  pr_vidx_i,
    input logic [GR_W-1:0]  gr_pidx_o,
    input logic [FR_W-1:0]  fr_pidx_o,
    input logic [PR_W-1:0]  pr_pidx_o,
    input logic [GR_W-1:0]  gr_base,
    input logic [FR_W-1:0]  fr_base,
    input logic [PR_W-1:0]  pr_base
);

    localparam logic [FR_W-1:0] FLO  = FR_W'(FR_LO);
    localparam logic [PR_W-1:0] PLO  = PR_W'(PR_LO);
    localparam logic [FR_W-1:0] FTOP = FR_W'(FR_SZ - 1);
    localparam logic [PR_W-1:0] PTOP = PR_W'(PR_SZ - 1);

    a_r2_fr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rotate_i && !clear_i) |=>
        fr_base == (($past(fr_base) == '0) ? FTOP : $past(fr_base) - FR_W'(1)));

    a_r2_pr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rotate_i && !clear_i) |=>
        pr_base == (($past(pr_base) == '0) ? PTOP : $past(pr_base) - PR_W'(1)));

    a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (gr_base == '0 && fr_base == '0 && pr_base == '0));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rotate_i && !clear_i) |=> $stable({gr_base, fr_base, pr_base}));

    a_r6_fr_static: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_vidx_i < FLO) |-> (fr_pidx_o == fr_vidx_i));

    a_r6_pr_static: assert property (@(posedge clk) disable iff (!rst_n)
        (pr_vidx_i < PLO) |-> (pr_pidx_o == pr_vidx_i));

    a_r3_fr_in_region: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_vidx_i >= FLO) |-> (fr_pidx_o >= FLO));

    a_r8_gr_off_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (gr_grp_i == '0) |-> (gr_pidx_o == gr_vidx_i));

    a_r8_gr_off_base: assert property (@(posedge clk) disable iff (!rst_n)
        (gr_grp_i == '0 && !clear_i && gr_base == '0) |=> (gr_base == '0));

endmodule

bind rot_base_renamer rot_base_renamer_chk #(
    .GR_W  (GR_W),
    .FR_W  (FR_W),
    .PR_W  (PR_W),
    .GRP_W (GRP_W),
    .FR_LO (FR_LO),
    .PR_LO (PR_LO),
    .FR_SZ (FR_REGS - FR_LO),
    .PR_SZ (PR_REGS - PR_LO)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rotate_i  (rotate_i),
    .clear_i   (clear_i),
    .gr_grp_i  (gr_grp_i),
    .gr_vidx_i (gr_vidx_i),
    .fr_vidx_i (fr_vidx_i),
    .pr_vidx_i (pr_vidx_i),
    .gr_pidx_o (gr_pidx_o),
    .fr_pidx_o (fr_pidx_o),
    .pr_pidx_o (pr_pidx_o),
    .gr_base   (gr_base),
    .fr_base   (fr_base),
    .pr_base   (pr_base)
);

// File: tb/rot_base_renamer_tb.sv
`timescale 1ns/1ps
module rot_base_renamer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rotate_i = 1'b0;
    logic       clear_i = 1'b0;
    logic [3:0] gr_grp_i = 4'd12;
    logic [6:0] gr_vidx_i = '0;
    logic [6:0] fr_vidx_i = '0;
    logic [5:0] pr_vidx_i = '0;
    logic [6:0] gr_pidx_o;
    logic [6:0] fr_pidx_o;
    logic [5:0] pr_pidx_o;

    always #2.5 clk = ~clk;

    rot_base_renamer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rotate_i  (rotate_i),
        .clear_i   (clear_i),
        .gr_grp_i  (gr_grp_i),
        .gr_vidx_i (gr_vidx_i),
        .fr_vidx_i (fr_vidx_i),
        .pr_vidx_i (pr_vidx_i),
        .gr_pidx_o (gr_pidx_o),
        .fr_pidx_o (fr_pidx_o),
        .pr_pidx_o (pr_pidx_o)
    );

    typedef struct {
        int    g;
        int    f;
        int    p;
        string tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    int   mg = 0, mf = 0, mp = 0;
    bit   done = 0;

    function automatic int mapv(int v, int lo, int size, int base);
        int b;
        if (size > 0 && v >= lo && v < lo + size) begin
            b = (base >= size) ? 0 : base;
            return lo + ((v - lo + b) % size);
        end
        return v;
    endfunction

    function automatic int dec(int base, int size);
        if (size == 0) return 0;
        if (base == 0 || base >= size) return size - 1;
        return base - 1;
    endfunction

    // Driver: one cycle per call; expectation uses the base before the edge.
    task automatic step(bit rot, bit clr, int grp, int gv, int fv, int pv, string tag);
        int   gsz;
        exp_t e;
        @(posedge clk);
        #1;
        rotate_i  = rot;
        clear_i   = clr;
        gr_grp_i  = 4'(grp);
        gr_vidx_i = 7'(gv);
        fr_vidx_i = 7'(fv);
        pr_vidx_i = 6'(pv);
        gsz   = ((grp > 12) ? 12 : grp) * 8;
        e.g   = mapv(gv, 32, gsz, mg);
        e.f   = mapv(fv, 32, 96, mf);
        e.p   = mapv(pv, 16, 48, mp);
        e.tag = tag;
        q.push_back(e);
        if (clr) begin
            mg = 0; mf = 0; mp = 0;
        end else if (rot) begin
            mg = dec(mg, gsz);
            mf = dec(mf, 96);
            mp = dec(mp, 48);
        end
    endtask

    // Monitor: compares away from the rising edge.
    always @(negedge clk) begin
        if (rst_n && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (int'(gr_pidx_o) != e.g || int'(fr_pidx_o) != e.f || int'(pr_pidx_o) != e.p) begin
                errors++;
                $display("FAIL %s: actual gr=%0d fr=%0d pr=%0d expected gr=%0d fr=%0d pr=%0d",
                         e.tag, gr_pidx_o, fr_pidx_o, pr_pidx_o, e.g, e.f, e.p);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: identity after reset
        step(0, 0, 12, 32,  32, 16, "R1 reset identity low");
        step(0, 0, 12, 127, 127, 63, "R1 reset identity high");

        // R10: rotate cycle still sees old base; R3/R4 after one rotate
        step(1, 0, 12, 32, 32, 16, "R10 strobe cycle old base");
        step(0, 0, 12, 32, 32, 16, "R3 fr32->127 R4 pr16->63");
        step(0, 0, 12, 33, 33, 17, "R3 fr33->32");

        // R6: static numbers pass through with nonzero bases
        step(0, 0, 12, 5, 31, 15, "R6 static pass");

        // R2: several rotates together
        for (int i = 0; i < 4; i++) step(1, 0, 12, 40, 100, 50, "R2 rotate run");
        step(0, 0, 12, 127, 127, 63, "R2 bases after five");

        // R2/R3/R4: full turns wrap back
        for (int i = 0; i < 91; i++) step(1, 0, 12, 70, 64, 30, "R2 long rotate");
        step(0, 0, 12, 32, 32, 16, "R3 fr full turn identity");

        // R7: clear with rotate, clear wins
        step(1, 1, 12, 50, 50, 40, "R7 clear and rotate");
        step(0, 0, 12, 50, 50, 40, "R7 bases zero after clear");

        // R5: clamp and small region
        step(1, 0, 15, 127, 32, 16, "R5 clamp grp15 rotate");
        step(0, 0, 15, 32, 32, 16, "R5 clamped region gr32->127");
        step(1, 1, 2, 32, 32, 16, "R7 clear again");
        step(1, 0, 2, 47, 32, 16, "R5 grp2 rotate");
        step(0, 0, 2, 32, 32, 16, "R5 grp2 gr32->47");
        step(0, 0, 2, 48, 32, 16, "R6 gr48 outside grp2 region");
        step(0, 0, 2, 20, 32, 16, "R6 gr below region");

        // R9: large base then shrink
        step(1, 1, 12, 32, 32, 16, "R7 clear before R9");
        for (int i = 0; i < 40; i++) step(1, 0, 12, 60, 60, 20, "R9 grow base");
        step(0, 0, 2, 33, 33, 17, "R9 stale base treated zero");
        step(1, 0, 2, 40, 33, 17, "R9 rotate from stale base");
        step(0, 0, 2, 32, 33, 17, "R9 base size minus one");

        // R8: rotation disabled for general class
        step(1, 1, 0, 32, 32, 16, "R7 clear before R8");
        step(1, 0, 0, 40, 32, 16, "R8 off rotate");
        step(1, 0, 0, 100, 32, 16, "R8 off rotate again");
        step(0, 0, 0, 32, 32, 16, "R8 off passthrough");
        step(0, 0, 12, 32, 32, 16, "R8 base stayed zero");

        step(0, 0, 12, 0, 0, 0, "R1 idle");
        repeat (3) @(posedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule